// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 interface and brings the memory device out of power-up. It drives the command pins (clock enable, chip select, the three strobes, bank and address) through the fixed bring-up order that a DDR2 device expects. It takes the four mode-register values as inputs and raises a single completion flag once the device is ready for normal traffic. The command issue, the fixed order and the minimum spacing between commands are all owned here. The stable-power wait is a parameterised count of cycles with clock enable held low. Data-path signals, calibration and normal read and write traffic are outside this block.

Nanosecond timing limits (precharge recovery, refresh cycle) are parameters given in picoseconds. They are turned into clock counts by rounding the quotient of the limit and the clock period upward. The load-mode spacing and the DLL lock time are given directly in clock cycles. Between commands the block drives a NOP with bank and address at zero.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, and in the first sampled cycle after it, the outputs are `cke`=0, `cs_n`=1, `ras_n`=`cas_n`=`we_n`=1, `ba`=0, `addr`=0 and `init_done`=0.
- R2: After reset is released, `cke` stays low for exactly CKE_LOW_CK sampled cycles, then rises and stays high until the next reset. While `cke` is low, `cs_n` is high.
- R3: Commands are encoded on {`cs_n`,`ras_n`,`cas_n`,`we_n`}: load-mode 0000, refresh 0001, precharge 0010, NOP 0111, and any cycle with `cs_n` high is a NOP. Every NOP cycle issued by the sequence drives `ba`=0 and `addr`=0.
- R4: The non-NOP commands, in order, are: precharge-all; load-mode to bank 3 with `mr3`, to bank 2 with `mr2`, to bank 1 with `mr1`, to bank 0 with `mr0` and bit 8 forced to 1; precharge-all; refresh; refresh; load-mode to bank 0 with `mr0` unchanged; load-mode to bank 1 with `mr1` and bits 9:7 forced to 111; load-mode to bank 1 with `mr1` unchanged. There are exactly 11 of them, and the sequence ends with a NOP.
- R5: A precharge-all drives `addr` bit 10 high with all other address bits and `ba` zero. A refresh drives `ba` and `addr` zero.
- R6: The first precharge-all is issued two cycles after the first cycle with `cke` high, with a NOP command in between.
- R7: The command after a precharge is issued exactly ceil(TRP_PS/CLK_PS) cycles after it.
- R8: The command after a refresh is issued exactly ceil(TRFC_PS/CLK_PS) cycles after it.
- R9: The command after a load-mode is issued exactly TMRD_CK cycles after it. The closing NOP follows the last load-mode by the same amount.
- R10: `init_done` first rises in cycle max(F+1, D+DLL_CK), where F is the closing NOP's cycle and D is the cycle of the DLL-reset load-mode. Once high it stays high with a NOP on the pins until reset.
- R11: Asserting `rst` in the middle of the sequence returns every output to its reset value. The next release runs the whole sequence again from the low-`cke` phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| mr0 | input | ADDR_W | Mode register 0 value |
| mr1 | input | ADDR_W | Extended mode register 1 value |
| mr2 | input | ADDR_W | Extended mode register 2 value |
| mr3 | input | ADDR_W | Extended mode register 3 value |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/column address and mode-register payload |
| init_done | output | 1 | Initialization complete |

## Verification
The DLL lock count and the end of the command sequence are independent, and both can decide the cycle in which `init_done` rises. The bench runs three copies side by side. In one copy the lock count dominates. In another the command sequence dominates. In the third, DLL_CK is chosen so that the cycle after the closing NOP is also the cycle in which the lock count elapses. That copy shows whether both conditions are honoured when they become true together, so that completion lands on that shared cycle with neither a one-cycle slip nor an early rise. Randomised mode-register values, including all-zero and all-one patterns, check that the forced DLL-reset and calibration bits merge correctly with whatever the caller supplies.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WR    = 4'b0100,
        CMD_RD    = 4'b0101,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_NOP_START,
        ST_PALL_A,
        ST_LM3,
        ST_LM2,
        ST_LM1,
        ST_LM0_DLL,
        ST_PALL_B,
        ST_REF_A,
        ST_REF_B,
        ST_LM0,
        ST_LM1_OCD,
        ST_LM1_FINAL,
        ST_NOP_END
    } step_e;

    typedef enum logic [1:0] {
        GAP_ONE,
        GAP_RP,
        GAP_MRD,
        GAP_RFC
    } gap_e;

    typedef enum logic [1:0] {
        PH_CKE_LOW,
        PH_SEQ,
        PH_DLL_WAIT,
        PH_READY
    } phase_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2i_step_table.sv
module ddr2i_step_table
    import ddr2i_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2,
    parameter int AP_BIT     = 10,
    parameter int DLLRST_BIT = 8,
    parameter int OCD_LSB    = 7
) (
    input  step_e              step,
    input  logic [ADDR_W-1:0]  mr0,
    input  logic [ADDR_W-1:0]  mr1,
    input  logic [ADDR_W-1:0]  mr2,
    input  logic [ADDR_W-1:0]  mr3,
    output cmd_e               cmd,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr,
    output gap_e               gap
);

    localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLLRST_BIT;
    localparam logic [ADDR_W-1:0] OCD_MASK = ADDR_W'(7) << OCD_LSB;

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        gap  = GAP_ONE;
        case (step)
            ST_NOP_START: begin
                cmd = CMD_NOP;
                gap = GAP_ONE;
            end
            ST_PALL_A, ST_PALL_B: begin
                cmd  = CMD_PRE;
                addr = AP_MASK;
                gap  = GAP_RP;
            end
            ST_LM3: begin
                cmd  = CMD_LMR;
                ba   = BA_W'(3);
                addr = mr3;
                gap  = GAP_MRD;
            end
            ST_LM2: begin
                cmd  = CMD_LMR;
                ba   = BA_W'(2);
                addr = mr2;
                gap  = GAP_MRD;
            end
            ST_LM1, ST_LM1_FINAL: begin
                cmd  = CMD_LMR;
                ba   = BA_W'(1);
                addr = mr1;
                gap  = GAP_MRD;
            end
            ST_LM1_OCD: begin
                cmd  = CMD_LMR;
                ba   = BA_W'(1);
                addr = mr1 | OCD_MASK;
                gap  = GAP_MRD;
            end
            ST_LM0_DLL: begin
                cmd  = CMD_LMR;
                addr = mr0 | DLL_MASK;
                gap  = GAP_MRD;
            end
            ST_LM0: begin
                cmd  = CMD_LMR;
                addr = mr0;
                gap  = GAP_MRD;
            end
            ST_REF_A, ST_REF_B: begin
                cmd = CMD_REF;
                gap = GAP_RFC;
            end
            ST_NOP_END: begin
                cmd = CMD_NOP;
                gap = GAP_ONE;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr2i_dll_timer.sv
module ddr2i_dll_timer #(
    parameter int LOCK_CK = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic elapsed
);

    localparam int CW = (LOCK_CK < 2) ? 1 : $clog2(LOCK_CK + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign elapsed = (cnt == LAST);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2,
    parameter int CLK_PS     = 10000,
    parameter int TRP_PS     = 13125,
    parameter int TRFC_PS    = 105000,
    parameter int TMRD_CK    = 2,
    parameter int DLL_CK     = 200,
    parameter int CKE_LOW_CK = 20,
    parameter int AP_BIT     = 10,
    parameter int DLLRST_BIT = 8,
    parameter int OCD_LSB    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mr0,
    input  logic [ADDR_W-1:0] mr1,
    input  logic [ADDR_W-1:0] mr2,
    input  logic [ADDR_W-1:0] mr3,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int TRP_CK  = at_least_one(ceil_div(TRP_PS, CLK_PS));
    localparam int TRFC_CK = at_least_one(ceil_div(TRFC_PS, CLK_PS));
    localparam int MRD_CK  = at_least_one(TMRD_CK);
    localparam int MAX_GAP = max_of(max_of(TRP_CK, TRFC_CK), MRD_CK);
    localparam int GAP_W   = (MAX_GAP < 2) ? 1 : $clog2(MAX_GAP + 1);
    localparam int PWR_W   = (CKE_LOW_CK < 2) ? 1 : $clog2(CKE_LOW_CK + 1);
    localparam logic [PWR_W-1:0] PWR_LAST = PWR_W'(at_least_one(CKE_LOW_CK) - 1);

    phase_e             phase;
    step_e              step;
    logic [GAP_W-1:0]   wcnt;
    logic [PWR_W-1:0]   pwr_cnt;
    logic               cke_q;
    cmd_e               cmd_q;
    logic [BA_W-1:0]    ba_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               done_q;

    cmd_e               tbl_cmd;
    logic [BA_W-1:0]    tbl_ba;
    logic [ADDR_W-1:0]  tbl_addr;
    gap_e               tbl_gap;
    logic [GAP_W-1:0]   gap_cycles;
    logic               issue;
    logic               dll_start;
    logic               dll_elapsed;

    ddr2i_step_table #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .AP_BIT     (AP_BIT),
        .DLLRST_BIT (DLLRST_BIT),
        .OCD_LSB    (OCD_LSB)
    ) u_table (
        .step (step),
        .mr0  (mr0),
        .mr1  (mr1),
        .mr2  (mr2),
        .mr3  (mr3),
        .cmd  (tbl_cmd),
        .ba   (tbl_ba),
        .addr (tbl_addr),
        .gap  (tbl_gap)
    );

    always_comb begin
        case (tbl_gap)
            GAP_RP:  gap_cycles = GAP_W'(TRP_CK);
            GAP_RFC: gap_cycles = GAP_W'(TRFC_CK);
            GAP_MRD: gap_cycles = GAP_W'(MRD_CK);
            default: gap_cycles = GAP_W'(1);
        endcase
    end

    assign issue     = (phase == PH_SEQ) && (wcnt == '0);
    assign dll_start = issue && (step == ST_LM0_DLL);

    ddr2i_dll_timer #(
        .LOCK_CK (at_least_one(DLL_CK))
    ) u_dll (
        .clk     (clk),
        .rst     (rst),
        .start   (dll_start),
        .elapsed (dll_elapsed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_CKE_LOW;
            step    <= ST_NOP_START;
            wcnt    <= '0;
            pwr_cnt <= '0;
            cke_q   <= 1'b0;
            cmd_q   <= CMD_DESEL;
            ba_q    <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (phase)
                PH_CKE_LOW: begin
                    if (pwr_cnt == PWR_LAST) begin
                        cke_q <= 1'b1;
                        cmd_q <= CMD_NOP;
                        phase <= PH_SEQ;
                        step  <= ST_NOP_START;
                        wcnt  <= '0;
                    end else begin
                        pwr_cnt <= pwr_cnt + PWR_W'(1);
                    end
                end
                PH_SEQ: begin
                    if (wcnt == '0) begin
                        cmd_q  <= tbl_cmd;
                        ba_q   <= tbl_ba;
                        addr_q <= tbl_addr;
                        wcnt   <= gap_cycles - GAP_W'(1);
                        if (step == ST_NOP_END) begin
                            phase <= PH_DLL_WAIT;
                        end else begin
                            step <= step_e'(step + 4'd1);
                        end
                    end else begin
                        cmd_q  <= CMD_NOP;
                        ba_q   <= '0;
                        addr_q <= '0;
                        wcnt   <= wcnt - GAP_W'(1);
                    end
                end
                PH_DLL_WAIT: begin
                    cmd_q  <= CMD_NOP;
                    ba_q   <= '0;
                    addr_q <= '0;
                    if (dll_elapsed) begin
                        done_q <= 1'b1;
                        phase  <= PH_READY;
                    end
                end
                default: begin
                    cmd_q  <= CMD_NOP;
                    ba_q   <= '0;
                    addr_q <= '0;
                end
            endcase
        end
    end

    assign cke       = cke_q;
    assign cs_n      = cmd_q[3];
    assign ras_n     = cmd_q[2];
    assign cas_n     = cmd_q[1];
    assign we_n      = cmd_q[0];
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign init_done = done_q;

endmodule

// File: rtl/ddr2i_init_chk.sv
module ddr2i_init_chk #(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2,
    parameter int AP_BIT     = 10,
    parameter int DLLRST_BIT = 8,
    parameter int DLL_CK     = 200,
    parameter int TRFC_CK    = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    localparam int CW = $clog2(DLL_CK + 2);

    logic [3:0]    cmd_w;
    logic          armed;
    logic [CW-1:0] since;

    assign cmd_w = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            since <= '0;
        end else if (!armed && cke && cmd_w == 4'b0000 && ba == '0 && addr[DLLRST_BIT]) begin
            armed <= 1'b1;
            since <= CW'(1);
        end else if (armed && since != CW'(DLL_CK)) begin
            since <= since + CW'(1);
        end
    end

    assert_cke_low_deselect_R2: assert property (@(posedge clk) disable iff (rst)
        !cke |-> cs_n);

    assert_cke_no_fall_R2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    assert_pall_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == 4'b0010) |-> (addr[AP_BIT] && ba == '0));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_nop_R10: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cs_n || {ras_n, cas_n, we_n} == 3'b111));

    assert_dll_window_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (armed && since >= CW'(DLL_CK)));

    generate
        if (TRFC_CK > 1) begin : g_ref_gap
            assert_ref_gap_R8: assert property (@(posedge clk) disable iff (rst)
                (cmd_w == 4'b0001) |=> (cmd_w == 4'b0111));
        end
    endgenerate

endmodule

bind ddr2_init_seq ddr2i_init_chk #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .AP_BIT     (AP_BIT),
    .DLLRST_BIT (DLLRST_BIT),
    .DLL_CK     (DLL_CK),
    .TRFC_CK    (TRFC_CK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;

    localparam int NI     = 3;
    localparam int CLK_PS = 10000;
    localparam int NCMD   = 11;
    localparam int DLLV  [NI] = '{200, 33, 10};
    localparam int TRPV  [NI] = '{13125, 13125, 25000};
    localparam int TRFCV [NI] = '{105000, 105000, 70000};
    localparam int TMRDV [NI] = '{2, 2, 3};
    localparam int CKEV  [NI] = '{20, 20, 5};

    typedef struct packed {
        logic [3:0]  c;
        logic [1:0]  b;
        logic [12:0] a;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] mr0 = '0, mr1 = '0, mr2 = '0, mr3 = '0;

    logic        cke_a  [NI];
    logic        csn_a  [NI];
    logic        rasn_a [NI];
    logic        casn_a [NI];
    logic        wen_a  [NI];
    logic [1:0]  ba_a   [NI];
    logic [12:0] addr_a [NI];
    logic        done_a [NI];

    int n_chk  = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    int t_i      [NI];
    int idx_i    [NI];
    bit seen_i   [NI];
    bit bad_cke  [NI];
    bit bad_nop  [NI];
    bit bad_hold [NI];
    int exp_t    [NI][NCMD];
    int exp_done [NI];

    always #5 clk = ~clk;

    ddr2_init_seq #(.CLK_PS(CLK_PS), .TRP_PS(TRPV[0]), .TRFC_PS(TRFCV[0]), .TMRD_CK(TMRDV[0]),
                    .DLL_CK(DLLV[0]), .CKE_LOW_CK(CKEV[0])) dut (
        .clk(clk), .rst(rst), .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3),
        .cke(cke_a[0]), .cs_n(csn_a[0]), .ras_n(rasn_a[0]), .cas_n(casn_a[0]), .we_n(wen_a[0]),
        .ba(ba_a[0]), .addr(addr_a[0]), .init_done(done_a[0]));

    ddr2_init_seq #(.CLK_PS(CLK_PS), .TRP_PS(TRPV[1]), .TRFC_PS(TRFCV[1]), .TMRD_CK(TMRDV[1]),
                    .DLL_CK(DLLV[1]), .CKE_LOW_CK(CKEV[1])) dut_eq (
        .clk(clk), .rst(rst), .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3),
        .cke(cke_a[1]), .cs_n(csn_a[1]), .ras_n(rasn_a[1]), .cas_n(casn_a[1]), .we_n(wen_a[1]),
        .ba(ba_a[1]), .addr(addr_a[1]), .init_done(done_a[1]));

    ddr2_init_seq #(.CLK_PS(CLK_PS), .TRP_PS(TRPV[2]), .TRFC_PS(TRFCV[2]), .TMRD_CK(TMRDV[2]),
                    .DLL_CK(DLLV[2]), .CKE_LOW_CK(CKEV[2])) dut_short (
        .clk(clk), .rst(rst), .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3),
        .cke(cke_a[2]), .cs_n(csn_a[2]), .ras_n(rasn_a[2]), .cas_n(casn_a[2]), .we_n(wen_a[2]),
        .ba(ba_a[2]), .addr(addr_a[2]), .init_done(done_a[2]));

    function automatic int cdiv(input int n, input int d);
        int q;
        q = n / d;
        if (q * d < n) q = q + 1;
        if (q < 1) q = 1;
        return q;
    endfunction

    // Expected k-th non-NOP command (R4, R5)
    function automatic ev_t exp_ev(input int k, input logic [12:0] m0, input logic [12:0] m1,
                                   input logic [12:0] m2, input logic [12:0] m3);
        ev_t e;
        e = '0;
        case (k)
            0, 5:  begin e.c = 4'b0010; e.a = 13'h0400; end
            1:     begin e.c = 4'b0000; e.b = 2'd3; e.a = m3; end
            2:     begin e.c = 4'b0000; e.b = 2'd2; e.a = m2; end
            3:     begin e.c = 4'b0000; e.b = 2'd1; e.a = m1; end
            4:     begin e.c = 4'b0000; e.b = 2'd0; e.a = m0 | 13'h0100; end
            6, 7:  begin e.c = 4'b0001; end
            8:     begin e.c = 4'b0000; e.b = 2'd0; e.a = m0; end
            9:     begin e.c = 4'b0000; e.b = 2'd1; e.a = m1 | 13'h0380; end
            default: begin e.c = 4'b0000; e.b = 2'd1; e.a = m1; end
        endcase
        return e;
    endfunction

    function automatic int gap_after(input int i, input logic [3:0] c);
        if (c == 4'b0010) return cdiv(TRPV[i], CLK_PS);
        if (c == 4'b0001) return cdiv(TRFCV[i], CLK_PS);
        return (TMRDV[i] < 1) ? 1 : TMRDV[i];
    endfunction

    task automatic chk(input bit ok, input string req, input int inst, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s inst%0d: actual %0d expected %0d", req, inst, act, exp);
        end
    endtask

    task automatic plan_run();
        for (int i = 0; i < NI; i++) begin
            int f, d, mrd;
            ev_t e;
            t_i[i] = 0; idx_i[i] = 0; seen_i[i] = 0;
            bad_cke[i] = 0; bad_nop[i] = 0; bad_hold[i] = 0;
            exp_t[i][0] = CKEV[i] + 2;
            for (int k = 1; k < NCMD; k++) begin
                e = exp_ev(k - 1, mr0, mr1, mr2, mr3);
                exp_t[i][k] = exp_t[i][k-1] + gap_after(i, e.c);
            end
            mrd = (TMRDV[i] < 1) ? 1 : TMRDV[i];
            f = exp_t[i][NCMD-1] + mrd;
            d = exp_t[i][4];
            exp_done[i] = (f + 1 > d + DLLV[i]) ? f + 1 : d + DLLV[i];
        end
    endtask

    // Monitor: samples on the falling edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            for (int i = 0; i < NI; i++) begin
                logic [3:0] cv;
                ev_t e;
                string tg;
                cv = {csn_a[i], rasn_a[i], casn_a[i], wen_a[i]};
                if (t_i[i] < CKEV[i]) begin
                    if (cke_a[i] || !csn_a[i]) bad_cke[i] = 1;
                end else if (t_i[i] == CKEV[i]) begin
                    chk(cke_a[i] == 1'b1, "R2 cke rise", i, cke_a[i], 1);
                end else if (!cke_a[i]) begin
                    bad_cke[i] = 1;
                end
                if (t_i[i] > CKEV[i] && cke_a[i] && !csn_a[i] && cv != 4'b0111) begin
                    if (idx_i[i] >= NCMD) begin
                        chk(0, "R4 extra command", i, idx_i[i], NCMD);
                    end else begin
                        e = exp_ev(idx_i[i], mr0, mr1, mr2, mr3);
                        tg = (e.c == 4'b0000) ? "R4" : "R5";
                        chk(cv == e.c, {tg, " cmd"}, i, cv, e.c);
                        chk(ba_a[i] == e.b, {tg, " ba"}, i, ba_a[i], e.b);
                        chk(addr_a[i] == e.a, {tg, " addr"}, i, addr_a[i], e.a);
                        if (idx_i[i] == 0) tg = "R6";
                        else begin
                            e = exp_ev(idx_i[i] - 1, mr0, mr1, mr2, mr3);
                            tg = (e.c == 4'b0010) ? "R7" : (e.c == 4'b0001) ? "R8" : "R9";
                        end
                        chk(t_i[i] == exp_t[i][idx_i[i]], {tg, " issue cycle"}, i, t_i[i], exp_t[i][idx_i[i]]);
                    end
                    idx_i[i]++;
                end else if (t_i[i] > CKEV[i]) begin
                    if (ba_a[i] != 0 || addr_a[i] != 0 || (!csn_a[i] && cv != 4'b0111)) bad_nop[i] = 1;
                end
                if (done_a[i] && !seen_i[i]) begin
                    seen_i[i] = 1;
                    chk(t_i[i] == exp_done[i], "R10 done cycle", i, t_i[i], exp_done[i]);
                end else if (seen_i[i] && !done_a[i]) begin
                    bad_hold[i] = 1;
                end
                t_i[i]++;
            end
        end
    end

    task automatic check_reset_state(input string tg);
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            chk(cke_a[i] == 0 && done_a[i] == 0, {tg, " cke/done"}, i, {cke_a[i], done_a[i]}, 0);
            chk({csn_a[i], rasn_a[i], casn_a[i], wen_a[i]} == 4'b1111, {tg, " strobes"}, i,
                {csn_a[i], rasn_a[i], casn_a[i], wen_a[i]}, 15);
            chk(ba_a[i] == 0 && addr_a[i] == 0, {tg, " ba/addr"}, i, addr_a[i], 0);
        end
    endtask

    task automatic start_run(input logic [12:0] a0, input logic [12:0] a1,
                             input logic [12:0] a2, input logic [12:0] a3, input string tg);
        @(posedge clk); #1;
        mon_on = 0;
        rst = 1;
        mr0 = a0; mr1 = a1; mr2 = a2; mr3 = a3;
        repeat (2) @(posedge clk);
        check_reset_state(tg);
        @(posedge clk); #1;
        plan_run();
        rst = 0;
        mon_on = 1;
    endtask

    task automatic end_run();
        for (int i = 0; i < NI; i++) begin
            chk(idx_i[i] == NCMD, "R4 command count", i, idx_i[i], NCMD);
            chk(!bad_cke[i], "R2 cke low window", i, bad_cke[i], 0);
            chk(!bad_nop[i], "R3 idle NOP zero", i, bad_nop[i], 0);
            chk(seen_i[i] && !bad_hold[i], "R10 done held", i, bad_hold[i], 0);
        end
    endtask

    initial begin
        process::self().srandom(32'h5eed_1234);
        void'($urandom(32'h2d1f));
        // R1: reset state, directed all-zero registers
        start_run(13'h0000, 13'h0000, 13'h0000, 13'h0000, "R1");
        repeat (260) @(posedge clk);
        end_run();
        // all-one registers: forced bits already set
        start_run(13'h1fff, 13'h1fff, 13'h1fff, 13'h1fff, "R1");
        repeat (260) @(posedge clk);
        end_run();
        // R11: abort mid-sequence, outputs must return to reset values
        start_run(13'($urandom), 13'($urandom), 13'($urandom), 13'($urandom), "R1");
        repeat (30) @(posedge clk);
        start_run(13'($urandom), 13'($urandom), 13'($urandom), 13'($urandom), "R11");
        repeat (260) @(posedge clk);
        end_run();
        for (int r = 0; r < 4; r++) begin
            start_run(13'($urandom), 13'($urandom), 13'($urandom), 13'($urandom), "R1");
            repeat (260) @(posedge clk);
            end_run();
        end
        mon_on = 0;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule